// File: doc/BRIEF.md
# Condition Register Execution Unit

This unit is the execute stage for the condition-register class of instructions in a 64-bit integer pipeline. Each cycle it takes an operation code, the raw 32-bit instruction word, two 64-bit operands, the current 32-bit condition register (CR) and an opaque context word. One clock edge later it presents the results. An integer result goes back to the general register file. A complete replacement CR is used for field-masked moves. A single 4-bit field, together with the field number it belongs in, is used for field copies and bit logic.

Each of the three results carries its own valid flag. A flag is raised only by the operations that really produce that result, so writeback logic can use the flags directly as write enables. The context word passes through the stage unchanged so that later stages can track the operation.

The CR is numbered big-endian. Field 0 is the most significant nibble, and CR bit n is physical bit 31-n. Within a field, the first bit (less-than) is the nibble's most significant bit.

Top module: `crfu_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first operation, every output is zero. Reset is asynchronous and active-low, and its release is synchronised over two clock edges.
- R2: Results and ctx_o appear on the clock edge after the inputs are sampled. ctx_o equals the ctx_i sampled on that edge.
- R3: For op_i=1 (move to CR), the mask is insn_i[19:12]. Mask bit j controls physical nibble cr[4j+3:4j], which is field 7-j. A field with its mask bit set takes the same nibble of opa_i, and any other field keeps its value from cr_i. Only cr_full_ok_o is raised.
- R4: For op_i=2 (move from CR) with insn_i[20]=0, int_res_o is cr_i zero-extended to 64 bits.
- R5: For op_i=2 with insn_i[20]=1, each nibble whose mask bit (insn_i[19:12], same mapping as R3) is set copies the CR nibble. All other bits of int_res_o are zero.
- R6: For op_i=3 (field copy), cr_fld_o is the CR field selected by insn_i[20:18] and cr_fld_idx_o is insn_i[25:23]. Only cr_fld_ok_o is raised.
- R7: For op_i=4 (bit logic), bit A is CR bit insn_i[20:16], bit B is CR bit insn_i[15:11], and the target is CR bit insn_i[25:21]. The result bit is truth-table bit insn_i[6+{A,B}]. The listed codes on insn_i[9:6] are: 1000 AND, 0100 A AND NOT B, 1001 XNOR, 0111 NAND, 0001 NOR, 1110 OR, 1101 A OR NOT B, and 0110 XOR. Every other code gives the function its table defines.
- R8: For op_i=4, cr_fld_idx_o is the target bit number divided by four. cr_fld_o is that whole field with only the target bit replaced, and the other three bits are kept from cr_i. Only cr_fld_ok_o is raised.
- R9: For op_i=5 (select), int_res_o is opa_i when CR bit insn_i[10:6] is 1, and opb_i when that bit is 0.
- R10: For op_i=6 (set boolean), take the field selected by insn_i[20:18]. int_res_o is all ones if the field's first bit is set. Otherwise it is 1 if the second bit is set, and otherwise it is 0.
- R11: int_ok_o is raised exactly for op_i values 2, 5 and 6. Codes 0 and 7 raise no valid flag, and at most one flag is high at any time.
- R12: CR bit n is physical bit 31-n, so CR bit 0 is cr_i[31] and CR bit 31 is cr_i[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (see R3 to R11) |
| insn_i | input | 32 | Raw instruction word, source of all field selectors |
| opa_i | input | 64 | First integer operand |
| opb_i | input | 64 | Second integer operand |
| cr_i | input | 32 | Current condition register |
| ctx_i | input | 16 | Operation context carried through |
| int_res_o | output | 64 | Integer result |
| int_ok_o | output | 1 | Integer result valid |
| cr_full_o | output | 32 | Full replacement CR |
| cr_full_ok_o | output | 1 | Full CR valid |
| cr_fld_o | output | 4 | Single updated CR field |
| cr_fld_idx_o | output | 3 | Field number for cr_fld_o |
| cr_fld_ok_o | output | 1 | Single field valid |
| ctx_o | output | 16 | Context, delayed one cycle |

## Verification
The bench runs every listed logic code plus one unlisted code on bits that sit in the middle of a field. A design that used little-endian numbering, or that swapped A and B in the table index, would write the wrong bit or the wrong value. A design that cleared the rest of the field would lose the three neighbour bits. Select is exercised at CR bits 0 and 31, where reversed numbering reads the opposite end of the register. Set boolean is tried with the first and second bits both set, to catch a reversed priority, and with neither set. The move-from-CR and move-to-CR tests use sparse masks, so a reversed mask-to-nibble mapping shows up. Unrecognised codes follow valid operations to expose valid flags that stick or leak.

// File: rtl/crfu_pkg.sv
package crfu_pkg;
  localparam int CR_W    = 32;
  localparam int FLD_W   = 4;
  localparam int NUM_FLD = CR_W / FLD_W;
  localparam int FIDX_W  = $clog2(NUM_FLD);
  localparam int BIDX_W  = $clog2(CR_W);

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_TO_CR     = 3'd1,
    OP_FROM_CR   = 3'd2,
    OP_FLD_COPY  = 3'd3,
    OP_BIT_LOGIC = 3'd4,
    OP_SELECT    = 3'd5,
    OP_SETBOOL   = 3'd6,
    OP_RSVD      = 3'd7
  } crfu_op_e;

  typedef struct packed {
    logic [BIDX_W-1:0]  tgt_bit;
    logic [BIDX_W-1:0]  src_a_bit;
    logic [BIDX_W-1:0]  src_b_bit;
    logic [FIDX_W-1:0]  dst_fld;
    logic [FIDX_W-1:0]  src_fld;
    logic [BIDX_W-1:0]  sel_bit;
    logic [NUM_FLD-1:0] nib_mask;
    logic [3:0]         table4;
    logic               one_fld;
  } crfu_fields_t;

  function automatic crfu_fields_t crfu_decode(input logic [31:0] w);
    crfu_fields_t f;
    f.tgt_bit   = w[25:21];
    f.src_a_bit = w[20:16];
    f.src_b_bit = w[15:11];
    f.dst_fld   = w[25:23];
    f.src_fld   = w[20:18];
    f.sel_bit   = w[10:6];
    f.nib_mask  = w[19:12];
    f.table4    = w[9:6];
    f.one_fld   = w[20];
    return f;
  endfunction

  // big-endian: CR bit n lives at physical position CR_W-1-n (= ~n for 5 bits)
  function automatic logic cr_bit(input logic [CR_W-1:0] cr, input logic [BIDX_W-1:0] n);
    return cr[~n];
  endfunction

  function automatic logic [FLD_W-1:0] cr_field(input logic [CR_W-1:0] cr,
                                                input logic [FIDX_W-1:0] k);
    return cr[{~k, 2'b11} -: FLD_W];
  endfunction
endpackage

// File: rtl/crfu_rst_sync.sv
module crfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/crfu_int_path.sv
module crfu_int_path
  import crfu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  crfu_op_e           op,
  input  logic [NUM_FLD-1:0] nib_mask,
  input  logic               one_fld,
  input  logic [BIDX_W-1:0]  sel_bit,
  input  logic [FIDX_W-1:0]  src_fld,
  input  logic [CR_W-1:0]    cr,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  output logic [DATA_W-1:0]  res,
  output logic               ok
);
  localparam int PAD_W = DATA_W - CR_W;

  logic [CR_W-1:0]  masked_cr;
  logic [FLD_W-1:0] sb_fld;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_nib
    assign masked_cr[g*FLD_W +: FLD_W] = nib_mask[g] ? cr[g*FLD_W +: FLD_W] : '0;
  end

  assign sb_fld = cr_field(cr, src_fld);

  always_comb begin
    res = '0;
    ok  = 1'b0;
    unique case (op)
      OP_FROM_CR: begin
        ok  = 1'b1;
        res = {{PAD_W{1'b0}}, (one_fld ? masked_cr : cr)};
      end
      OP_SELECT: begin
        ok  = 1'b1;
        res = cr_bit(cr, sel_bit) ? opa : opb;
      end
      OP_SETBOOL: begin
        ok = 1'b1;
        if (sb_fld[3])      res = '1;
        else if (sb_fld[2]) res = DATA_W'(1);
        else                res = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/crfu_cr_path.sv
module crfu_cr_path
  import crfu_pkg::*;
(
  input  crfu_op_e           op,
  input  logic [NUM_FLD-1:0] nib_mask,
  input  logic [FIDX_W-1:0]  dst_fld,
  input  logic [FIDX_W-1:0]  src_fld,
  input  logic [BIDX_W-1:0]  tgt_bit,
  input  logic [BIDX_W-1:0]  src_a_bit,
  input  logic [BIDX_W-1:0]  src_b_bit,
  input  logic [3:0]         table4,
  input  logic [CR_W-1:0]    cr,
  input  logic [CR_W-1:0]    opa_lo,
  output logic [CR_W-1:0]    full_cr,
  output logic               full_ok,
  output logic [FLD_W-1:0]   fld,
  output logic [FIDX_W-1:0]  fld_idx,
  output logic               fld_ok
);
  logic [CR_W-1:0]  merged_cr;
  logic             bit_a, bit_b, logic_bit;
  logic [FLD_W-1:0] tgt_fld;
  logic [1:0]       pos_in_fld;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_merge
    assign merged_cr[g*FLD_W +: FLD_W] =
      nib_mask[g] ? opa_lo[g*FLD_W +: FLD_W] : cr[g*FLD_W +: FLD_W];
  end

  assign bit_a      = cr_bit(cr, src_a_bit);
  assign bit_b      = cr_bit(cr, src_b_bit);
  assign logic_bit  = table4[{bit_a, bit_b}];
  assign pos_in_fld = ~tgt_bit[1:0];   // first field bit is nibble MSB

  always_comb begin
    tgt_fld             = cr_field(cr, tgt_bit[BIDX_W-1:2]);
    tgt_fld[pos_in_fld] = logic_bit;
  end

  always_comb begin
    full_cr = merged_cr;
    full_ok = (op == OP_TO_CR);
    fld     = '0;
    fld_idx = '0;
    fld_ok  = 1'b0;
    if (op == OP_FLD_COPY) begin
      fld     = cr_field(cr, src_fld);
      fld_idx = dst_fld;
      fld_ok  = 1'b1;
    end else if (op == OP_BIT_LOGIC) begin
      fld     = tgt_fld;
      fld_idx = tgt_bit[BIDX_W-1:2];
      fld_ok  = 1'b1;
    end
  end
endmodule

// File: rtl/crfu_unit.sv
module crfu_unit
  import crfu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [DATA_W-1:0] int_res_o,
  output logic              int_ok_o,
  output logic [CR_W-1:0]   cr_full_o,
  output logic              cr_full_ok_o,
  output logic [FLD_W-1:0]  cr_fld_o,
  output logic [FIDX_W-1:0] cr_fld_idx_o,
  output logic              cr_fld_ok_o,
  output logic [CTX_W-1:0]  ctx_o
);
  logic         rst_sync_n;
  crfu_fields_t f_s;
  crfu_op_e     op_s;

  logic [DATA_W-1:0] int_res_d;
  logic              int_ok_d, full_ok_d, fld_ok_d;
  logic [CR_W-1:0]   full_d;
  logic [FLD_W-1:0]  fld_d;
  logic [FIDX_W-1:0] fld_idx_d;

  crfu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign f_s  = crfu_decode(insn_i);
  assign op_s = crfu_op_e'(op_i);

  crfu_int_path #(.DATA_W(DATA_W)) u_int (
    .op(op_s), .nib_mask(f_s.nib_mask), .one_fld(f_s.one_fld),
    .sel_bit(f_s.sel_bit), .src_fld(f_s.src_fld), .cr(cr_i),
    .opa(opa_i), .opb(opb_i), .res(int_res_d), .ok(int_ok_d)
  );

  crfu_cr_path u_cr (
    .op(op_s), .nib_mask(f_s.nib_mask), .dst_fld(f_s.dst_fld),
    .src_fld(f_s.src_fld), .tgt_bit(f_s.tgt_bit), .src_a_bit(f_s.src_a_bit),
    .src_b_bit(f_s.src_b_bit), .table4(f_s.table4), .cr(cr_i),
    .opa_lo(opa_i[CR_W-1:0]), .full_cr(full_d), .full_ok(full_ok_d),
    .fld(fld_d), .fld_idx(fld_idx_d), .fld_ok(fld_ok_d)
  );

  // flags and context every cycle; payloads only when their flag is set
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      int_ok_o     <= 1'b0;
      cr_full_ok_o <= 1'b0;
      cr_fld_ok_o  <= 1'b0;
      ctx_o        <= '0;
    end else begin
      int_ok_o     <= int_ok_d;
      cr_full_ok_o <= full_ok_d;
      cr_fld_ok_o  <= fld_ok_d;
      ctx_o        <= ctx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   int_res_o <= '0;
    else if (int_ok_d) int_res_o <= int_res_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    cr_full_o <= '0;
    else if (full_ok_d) cr_full_o <= full_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cr_fld_o     <= '0;
      cr_fld_idx_o <= '0;
    end else if (fld_ok_d) begin
      cr_fld_o     <= fld_d;
      cr_fld_idx_o <= fld_idx_d;
    end
  end
endmodule

// File: rtl/crfu_chk.sv
module crfu_chk #(
  parameter int DATA_W = 64,
  parameter int CTX_W  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [2:0]        op_i,
  input logic [31:0]       insn_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [31:0]       cr_i,
  input logic [CTX_W-1:0]  ctx_i,
  input logic [DATA_W-1:0] int_res_o,
  input logic              int_ok_o,
  input logic              cr_full_ok_o,
  input logic              cr_fld_ok_o,
  input logic [CTX_W-1:0]  ctx_o
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  // R11
  ok_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({int_ok_o, cr_full_ok_o, cr_fld_ok_o}) <= 1);

  // R3
  full_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (cr_full_ok_o == ($past(op_i) == 3'd1)));

  // R6
  fld_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (cr_fld_ok_o == ($past(op_i) == 3'd3 || $past(op_i) == 3'd4)));

  // R11
  int_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (int_ok_o == ($past(op_i) == 3'd2 || $past(op_i) == 3'd5 ||
                             $past(op_i) == 3'd6)));

  // R2
  ctx_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (ctx_o == $past(ctx_i)));

  // R9
  select_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_q && $past(op_i) == 3'd5) |->
      (int_res_o == ($past(cr_i[~insn_i[10:6]]) ? $past(opa_i) : $past(opb_i))));

  // R4
  from_cr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_q && $past(op_i) == 3'd2 && !$past(insn_i[20])) |->
      (int_res_o == DATA_W'($past(cr_i))));
endmodule

bind crfu_unit crfu_chk #(.DATA_W(DATA_W), .CTX_W(CTX_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_i(op_i), .insn_i(insn_i),
  .opa_i(opa_i), .opb_i(opb_i), .cr_i(cr_i), .ctx_i(ctx_i),
  .int_res_o(int_res_o), .int_ok_o(int_ok_o), .cr_full_ok_o(cr_full_ok_o),
  .cr_fld_ok_o(cr_fld_ok_o), .ctx_o(ctx_o)
);

// File: tb/crfu_unit_tb.sv
module crfu_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [31:0] insn_i;
  logic [63:0] opa_i, opb_i;
  logic [31:0] cr_i;
  logic [15:0] ctx_i;
  logic [63:0] int_res_o;
  logic        int_ok_o;
  logic [31:0] cr_full_o;
  logic        cr_full_ok_o;
  logic [3:0]  cr_fld_o;
  logic [2:0]  cr_fld_idx_o;
  logic        cr_fld_ok_o;
  logic [15:0] ctx_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  crfu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .insn_i(insn_i), .opa_i(opa_i),
    .opb_i(opb_i), .cr_i(cr_i), .ctx_i(ctx_i), .int_res_o(int_res_o),
    .int_ok_o(int_ok_o), .cr_full_o(cr_full_o), .cr_full_ok_o(cr_full_ok_o),
    .cr_fld_o(cr_fld_o), .cr_fld_idx_o(cr_fld_idx_o), .cr_fld_ok_o(cr_fld_ok_o),
    .ctx_o(ctx_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic crb(input logic [31:0] cr, input int n);
    return cr[31-n];
  endfunction

  function automatic logic [3:0] crf(input logic [31:0] cr, input int k);
    return cr[31-4*k -: 4];
  endfunction

  function automatic logic [31:0] mk_logic(input int bt, input int ba, input int bb,
                                           input logic [3:0] code);
    logic [31:0] w = '0;
    w[25:21] = 5'(bt); w[20:16] = 5'(ba); w[15:11] = 5'(bb); w[9:6] = code;
    return w;
  endfunction

  // apply at negedge, sample at the following negedge (one register stage)
  task automatic issue(input logic [2:0] op, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] cr, input logic [15:0] ctx);
    @(negedge clk);
    op_i = op; insn_i = w; opa_i = a; opb_i = b; cr_i = cr; ctx_i = ctx;
    @(negedge clk);
  endtask

  task automatic flags(input string req, input bit ei, input bit ef, input bit ed);
    check(int_ok_o == ei,     req, 64'(int_ok_o), 64'(ei));
    check(cr_full_ok_o == ef, req, 64'(cr_full_ok_o), 64'(ef));
    check(cr_fld_ok_o == ed,  req, 64'(cr_fld_ok_o), 64'(ed));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_i = '0; insn_i = '0; opa_i = '0; opb_i = '0; cr_i = '0; ctx_i = '0;
    repeat (3) @(negedge clk);
    check(int_res_o == 0 && cr_full_o == 0 && cr_fld_o == 0 && ctx_o == 0,
          "R1 in reset", int_res_o, 0);
    flags("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(int_res_o == 0 && cr_full_o == 0 && cr_fld_o == 0 && cr_fld_idx_o == 0,
          "R1 after release", int_res_o, 0);
    flags("R1 after release", 0, 0, 0);
  endtask

  task automatic t_to_cr();
    logic [31:0] w = '0;
    logic [31:0] exp;
    w[19:12] = 8'b1000_0101;   // physical nibbles 7, 2, 0
    issue(3'd1, w, 64'hFFFF_FFFF_ABCD_EF12, '0, 32'h1234_5678, 16'hA5A5);
    exp = 32'hA234_5F72;
    check(cr_full_o == exp, "R3 masked merge", 64'(cr_full_o), 64'(exp));
    flags("R3 flags", 0, 1, 0);
    check(ctx_o == 16'hA5A5, "R2 context", 64'(ctx_o), 64'hA5A5);
  endtask

  task automatic t_from_cr();
    logic [31:0] w = '0;
    issue(3'd2, w, '0, '0, 32'hDEAD_BEEF, 16'h0001);
    check(int_res_o == 64'h0000_0000_DEAD_BEEF, "R4 plain", int_res_o, 64'hDEAD_BEEF);
    flags("R11 from-cr flags", 1, 0, 0);
    w[20] = 1'b1; w[19:12] = 8'b0100_0010;   // nibbles 6 and 1
    issue(3'd2, w, '0, '0, 32'hDEAD_BEEF, 16'h0002);
    check(int_res_o == 64'h0000_0000_0E00_00E0, "R5 one-field", int_res_o,
          64'h0E00_00E0);
  endtask

  task automatic t_fld_copy();
    logic [31:0] w = '0;
    logic [31:0] cr = 32'h0123_4567;
    w[25:23] = 3'd6; w[20:18] = 3'd2;
    issue(3'd3, w, '0, '0, cr, '0);
    check(cr_fld_o == crf(cr, 2), "R6 copy value", 64'(cr_fld_o), 64'(crf(cr, 2)));
    check(cr_fld_idx_o == 3'd6, "R6 copy index", 64'(cr_fld_idx_o), 64'd6);
    flags("R6 flags", 0, 0, 1);
  endtask

  task automatic t_logic();
    logic [3:0] codes [9] = '{4'b1000, 4'b0100, 4'b1001, 4'b0111, 4'b0001,
                              4'b1110, 4'b1101, 4'b0110, 4'b0011};
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 9; c++) begin
        logic a = p[1];
        logic b = p[0];
        logic r;
        logic [31:0] cr = 32'h5A5A_5A5A;
        logic [3:0] ef;
        cr[31-9]  = a;   // bit A = CR bit 9
        cr[31-22] = b;   // bit B = CR bit 22
        case (c)
          0: r = a & b;
          1: r = a & ~b;
          2: r = ~(a ^ b);
          3: r = ~(a & b);
          4: r = ~(a | b);
          5: r = a | b;
          6: r = a | ~b;
          7: r = a ^ b;
          default: r = ~a;   // unlisted 0011 per table
        endcase
        issue(3'd4, mk_logic(14, 9, 22, codes[c]), '0, '0, cr, 16'(c));
        ef = crf(cr, 3);
        ef[3 - (14 % 4)] = r;
        check(cr_fld_o == ef, "R7 R12 logic result", 64'(cr_fld_o), 64'(ef));
        check(cr_fld_idx_o == 3'd3, "R8 logic index", 64'(cr_fld_idx_o), 64'd3);
      end
    end
    flags("R8 logic flags", 0, 0, 1);
  endtask

  task automatic t_select();
    logic [31:0] w = '0;
    w[10:6] = 5'd0;
    issue(3'd5, w, 64'h1111, 64'h2222, 32'h8000_0000, '0);
    check(int_res_o == 64'h1111, "R9 R12 bit 0 set", int_res_o, 64'h1111);
    w[10:6] = 5'd31;
    issue(3'd5, w, 64'h1111, 64'h2222, 32'h8000_0000, '0);
    check(int_res_o == 64'h2222, "R9 R12 bit 31 clear", int_res_o, 64'h2222);
    issue(3'd5, w, 64'h3333, 64'h4444, 32'h0000_0001, '0);
    check(int_res_o == 64'h3333, "R9 R12 bit 31 set", int_res_o, 64'h3333);
    flags("R11 select flags", 1, 0, 0);
  endtask

  task automatic t_setbool();
    logic [31:0] w = '0;
    w[20:18] = 3'd5;
    issue(3'd6, w, '0, '0, 32'h0000_0C00, '0);
    check(int_res_o == '1, "R10 first bit wins", int_res_o, '1);
    issue(3'd6, w, '0, '0, 32'h0000_0400, '0);
    check(int_res_o == 64'd1, "R10 second bit", int_res_o, 64'd1);
    issue(3'd6, w, '0, '0, 32'hFFFF_F3FF, '0);
    check(int_res_o == 64'd0, "R10 neither", int_res_o, 64'd0);
  endtask

  task automatic t_unknown();
    issue(3'd0, 32'hFFFF_FFFF, '1, '1, '1, 16'h0BAD);
    flags("R11 code 0", 0, 0, 0);
    issue(3'd7, 32'hFFFF_FFFF, '1, '1, '1, 16'h0BAD);
    flags("R11 code 7", 0, 0, 0);
    check(ctx_o == 16'h0BAD, "R2 context on unknown", 64'(ctx_o), 64'h0BAD);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_to_cr();
        t_from_cr();
        t_fld_copy();
        t_logic();
        t_select();
        t_setbool();
        t_unknown();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_vec++; n_bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule